// File: doc/BRIEF.md
# Serial Receive Unit with Idle-Line Timeout

This block is the receive side of an asynchronous serial port. It watches a single input line, finds the start of each character with a 16x oversampling clock enable, and reassembles 5 to 8 data bits. It can check one parity bit and one or two stop bits. Each finished character is stored with its own error flags in a 16-entry queue, which software drains one entry at a time.

Three interrupt conditions help software decide when to read. The fill-level condition is true once enough characters are waiting. The idle-line timeout catches a short burst that never reaches that level. The error condition reflects a lost character or a damaged character at the head of the queue. A lost character sets a sticky overrun flag that stays set until a dedicated clear strobe. The parity, framing and break indications are not sticky: each follows the entry currently at the head of the queue and goes away when that entry is popped.

Top module: `serial_rx_unit`

## Requirements
- R1: After reset the queue is empty (count 0, data-available 0, not-full 1), the receiver is not busy, and every error and interrupt output is 0.
- R2: A frame is a low start bit, then data bits LSB first, then optional parity, then stop bits. The word-length code 00/01/10/11 selects 5/6/7/8 data bits. The character appears in rd_data[7:0] with the unused upper data bits at zero.
- R3: A start bit is accepted only if the line is still low at the 8th oversample after the falling edge. A shorter low pulse produces no character and the receiver returns to not busy.
- R4: When parity is enabled, par_even=1 selects even parity and par_even=0 selects odd parity. A mismatch sets rd_data[15] and the parity error output for that character.
- R5: A low stop bit sets rd_data[14] and the framing error output. In two-stop mode a low second stop bit also counts.
- R6: A character whose data bits, parity bit and first stop bit are all low is flagged as a break in rd_data[13] and on the break output (framing is also set). Reception resumes only after the line returns high.
- R7: The queue holds 16 characters in arrival order and reports its count, data-available and not-full. A pop while the queue is empty has no effect.
- R8: A character that completes while the queue is full and no pop occurs in that cycle is dropped and sets the sticky overrun flag. If a pop occurs in that same cycle, the character is accepted. The clear strobe resets overrun, but a new overrun in the same cycle wins.
- R9: The fill-level interrupt is high exactly when the queue count is greater than or equal to the trigger level.
- R10: The timeout interrupt rises after 32 bit-times without line activity while the queue is not empty. It falls on a pop, on a new start bit, or when the queue empties.
- R11: The error interrupt is high when overrun is set or the head entry carries a parity, framing or break flag.
- R12: While rx_en is low the line is ignored and no character is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en_i | input | 1 | Receiver enable |
| rxd_i | input | 1 | Serial line, idle high |
| os_tick_i | input | 1 | 16x oversampling enable |
| wlen_i | input | 2 | Word length code (00=5 .. 11=8 bits) |
| two_stop_i | input | 1 | Two stop bits when 1 |
| par_en_i | input | 1 | Parity bit present |
| par_even_i | input | 1 | Even parity when 1, odd when 0 |
| trig_lvl_i | input | 5 | Fill-level interrupt threshold |
| pop_i | input | 1 | Remove head entry |
| ovr_clr_i | input | 1 | Clear the overrun flag |
| rd_data_o | output | 16 | Head entry: data 7:0, break 13, framing 14, parity 15 |
| data_avail_o | output | 1 | Queue not empty |
| not_full_o | output | 1 | Queue has space |
| fifo_cnt_o | output | 5 | Queue count |
| busy_o | output | 1 | Frame in progress |
| ovr_err_o | output | 1 | Sticky overrun |
| frm_err_o | output | 1 | Head entry framing error |
| par_err_o | output | 1 | Head entry parity error |
| brk_err_o | output | 1 | Head entry break |
| irq_thresh_o | output | 1 | Fill-level interrupt |
| irq_timeout_o | output | 1 | Idle timeout interrupt |
| irq_err_o | output | 1 | Error interrupt |

## Verification
Two events can land in the same clock cycle: a character finishing its stop bit while the queue is full, and a software pop or overrun clear. The bench fills the queue and then sends one more character. It watches busy fall, which marks the completion cycle, and drives pop in exactly that cycle. The expected result is an unchanged count of 16, no overrun, and the second-oldest character now at the head. A second character is then timed the same way, this time with the clear strobe instead of pop. The expected result is that overrun reads set, because a new overrun beats a simultaneous clear.

// File: rtl/rx_pkg.sv
package rx_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_STOP2, S_WAIT_HI
    } rx_state_e;

    typedef struct packed {
        logic       brk;
        logic       frm;
        logic       par;
        logic [7:0] data;
    } rx_char_t;

    localparam int CHAR_W = $bits(rx_char_t);
endpackage

// File: rtl/rx_frame_sampler.sv
module rx_frame_sampler
    import rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en_i,
    input  logic     rxd_i,
    input  logic     tick_i,
    input  logic [1:0] wlen_i,
    input  logic     two_stop_i,
    input  logic     par_en_i,
    input  logic     par_even_i,
    output logic     busy_o,
    output logic     vld_o,
    output rx_char_t chr_o
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    typedef struct packed {
        rx_state_e   state;
        logic [CW-1:0] cnt;
        logic [2:0]  idx;
        logic [7:0]  data;
        logic        par_bit;
        logic        frm;
        logic        zero;
        logic        s1;
        logic        s2;
        logic        vld;
        rx_char_t    chr;
    } smp_t;

    smp_t q, n;
    logic emit, xp, par_bad;
    logic [7:0] mask;

    assign mask    = 8'hFF >> (2'd3 - wlen_i);
    assign xp      = (^(q.data & mask)) ^ q.par_bit;
    assign par_bad = par_even_i ? xp : ~xp;

    always_comb begin
        n      = q;
        n.s1   = rxd_i;
        n.s2   = q.s1;
        n.vld  = 1'b0;
        emit   = 1'b0;
        if (!en_i) begin
            n.state = S_IDLE;
            n.cnt   = '0;
        end else if (tick_i) begin
            unique case (q.state)
                S_IDLE: if (!q.s2) begin
                    n.state = S_START;
                    n.cnt   = '0;
                end
                S_START: if (q.cnt == MID) begin
                    n.cnt = '0;
                    if (!q.s2) begin
                        n.state   = S_DATA;
                        n.idx     = '0;
                        n.data    = '0;
                        n.zero    = 1'b1;
                        n.frm     = 1'b0;
                        n.par_bit = 1'b0;
                    end else begin
                        n.state = S_IDLE;
                    end
                end else n.cnt = q.cnt + 1'b1;
                S_DATA: if (q.cnt == LAST) begin
                    n.cnt         = '0;
                    n.data[q.idx] = q.s2;
                    if (q.s2) n.zero = 1'b0;
                    if (q.idx == ({1'b0, wlen_i} + 3'd4))
                        n.state = par_en_i ? S_PAR : S_STOP;
                    else
                        n.idx = q.idx + 1'b1;
                end else n.cnt = q.cnt + 1'b1;
                S_PAR: if (q.cnt == LAST) begin
                    n.cnt     = '0;
                    n.par_bit = q.s2;
                    if (q.s2) n.zero = 1'b0;
                    n.state   = S_STOP;
                end else n.cnt = q.cnt + 1'b1;
                S_STOP: if (q.cnt == LAST) begin
                    n.cnt = '0;
                    if (q.s2) n.zero = 1'b0;
                    else      n.frm  = 1'b1;
                    if (two_stop_i) n.state = S_STOP2;
                    else            emit    = 1'b1;
                end else n.cnt = q.cnt + 1'b1;
                S_STOP2: if (q.cnt == LAST) begin
                    n.cnt = '0;
                    if (!q.s2) n.frm = 1'b1;
                    emit = 1'b1;
                end else n.cnt = q.cnt + 1'b1;
                S_WAIT_HI: if (q.s2) n.state = S_IDLE;
                default: n.state = S_IDLE;
            endcase
        end
        if (emit) begin
            n.vld      = 1'b1;
            n.chr.data = n.data;
            n.chr.frm  = n.frm;
            n.chr.brk  = n.zero;
            n.chr.par  = par_en_i & par_bad;
            n.state    = n.frm ? S_WAIT_HI : S_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= S_IDLE;
            q.s1    <= 1'b1;
            q.s2    <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign busy_o = (q.state != S_IDLE);
    assign vld_o  = q.vld;
    assign chr_o  = q.chr;

    // R12
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (q.state == S_IDLE));

    // R3
    start_from_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_START && $past(q.state) == S_IDLE) |-> !$past(q.s2));
endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 11
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic [W-1:0]               din_i,
    input  logic                       pop_i,
    output logic [W-1:0]               head_o,
    output logic [$clog2(DEPTH+1)-1:0] cnt_o,
    output logic                       empty_o,
    output logic                       full_o,
    output logic                       drop_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_t;

    fifo_t q, n;
    logic [W-1:0] mem [DEPTH];
    logic pop_ok, acc;

    assign empty_o = (q.cnt == '0);
    assign full_o  = (q.cnt == CW'(DEPTH));
    assign pop_ok  = pop_i && !empty_o;
    assign acc     = push_i && (!full_o || pop_ok);
    assign drop_o  = push_i && !acc;

    always_comb begin
        n = q;
        if (acc)    n.wp = (q.wp == TOP) ? '0 : q.wp + 1'b1;
        if (pop_ok) n.rp = (q.rp == TOP) ? '0 : q.rp + 1'b1;
        if (acc && !pop_ok)      n.cnt = q.cnt + 1'b1;
        else if (!acc && pop_ok) n.cnt = q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_ff @(posedge clk) begin
        if (acc) mem[q.wp] <= din_i;
    end

    assign head_o = mem[q.rp];
    assign cnt_o  = q.cnt;

    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !full_o) |=> (q.cnt == $past(q.cnt) + 1'b1));
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
    parameter int LIMIT = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic hold_i,
    input  logic restart_i,
    input  logic empty_i,
    output logic fire_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] END = CW'(LIMIT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flag;
    } tmr_t;

    tmr_t q, n;

    always_comb begin
        n = q;
        if (empty_i || restart_i || hold_i) begin
            n.cnt  = '0;
            n.flag = 1'b0;
        end else if (tick_i && !q.flag) begin
            if (q.cnt == END) n.flag = 1'b1;
            else              n.cnt  = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign fire_o = q.flag;
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
    import rx_pkg::*;
#(
    parameter int OSR     = 16,
    parameter int DEPTH   = 16,
    parameter int TO_BITS = 32,
    localparam int CNTW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_en_i,
    input  logic            rxd_i,
    input  logic            os_tick_i,
    input  logic [1:0]      wlen_i,
    input  logic            two_stop_i,
    input  logic            par_en_i,
    input  logic            par_even_i,
    input  logic [CNTW-1:0] trig_lvl_i,
    input  logic            pop_i,
    input  logic            ovr_clr_i,
    output logic [15:0]     rd_data_o,
    output logic            data_avail_o,
    output logic            not_full_o,
    output logic [CNTW-1:0] fifo_cnt_o,
    output logic            busy_o,
    output logic            ovr_err_o,
    output logic            frm_err_o,
    output logic            par_err_o,
    output logic            brk_err_o,
    output logic            irq_thresh_o,
    output logic            irq_timeout_o,
    output logic            irq_err_o
);
    localparam int TO_TICKS = TO_BITS * OSR;

    logic     chr_vld, fifo_empty, fifo_full, fifo_drop, busy;
    rx_char_t chr, head;
    logic [CHAR_W-1:0] head_raw;
    logic [CNTW-1:0]   cnt;
    logic ovr_d, ovr_q;

    rx_frame_sampler #(.OSR(OSR)) i_sampler (
        .clk(clk), .rst_n(rst_n), .en_i(rx_en_i), .rxd_i(rxd_i),
        .tick_i(os_tick_i), .wlen_i(wlen_i), .two_stop_i(two_stop_i),
        .par_en_i(par_en_i), .par_even_i(par_even_i),
        .busy_o(busy), .vld_o(chr_vld), .chr_o(chr)
    );

    rx_char_fifo #(.DEPTH(DEPTH), .W(CHAR_W)) i_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(chr_vld), .din_i(chr),
        .pop_i(pop_i), .head_o(head_raw), .cnt_o(cnt),
        .empty_o(fifo_empty), .full_o(fifo_full), .drop_o(fifo_drop)
    );

    rx_idle_timer #(.LIMIT(TO_TICKS)) i_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(os_tick_i), .hold_i(busy),
        .restart_i(chr_vld | (pop_i & ~fifo_empty)), .empty_i(fifo_empty),
        .fire_o(irq_timeout_o)
    );

    assign head = rx_char_t'(head_raw);

    always_comb begin
        ovr_d = ovr_q;
        if (ovr_clr_i) ovr_d = 1'b0;
        if (fifo_drop) ovr_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovr_q <= 1'b0;
        else        ovr_q <= ovr_d;
    end

    assign data_avail_o = !fifo_empty;
    assign not_full_o   = !fifo_full;
    assign fifo_cnt_o   = cnt;
    assign busy_o       = busy;
    assign rd_data_o    = data_avail_o ? {head.par, head.frm, head.brk, 5'b0, head.data} : 16'h0;
    assign par_err_o    = data_avail_o & head.par;
    assign frm_err_o    = data_avail_o & head.frm;
    assign brk_err_o    = data_avail_o & head.brk;
    assign ovr_err_o    = ovr_q;
    assign irq_thresh_o = (cnt >= trig_lvl_i);
    assign irq_err_o    = ovr_q | par_err_o | frm_err_o | brk_err_o;

    // R8
    drop_sets_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_drop |=> ovr_q);

    // R8
    clr_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && ovr_clr_i && !fifo_drop) |=> !ovr_q);

    // R10
    to_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_timeout_o |-> data_avail_o);
endmodule

// File: tb/test_serial_rx_unit.sv
module test_serial_rx_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0, rxd = 1'b1;
    logic [1:0] wlen = 2'd3;
    logic two_stop = 1'b0, par_en = 1'b0, par_even = 1'b0;
    logic [4:0] trig = 5'd16;
    logic pop = 1'b0, ovr_clr = 1'b0;
    logic [15:0] rd_data;
    logic avail, not_full, busy, ovr, frm, par, brk, irq_th, irq_to, irq_er;
    logic [4:0] cnt;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    serial_rx_unit i_serial_rx_unit (
        .clk(clk), .rst_n(rst_n), .rx_en_i(rx_en), .rxd_i(rxd), .os_tick_i(1'b1),
        .wlen_i(wlen), .two_stop_i(two_stop), .par_en_i(par_en), .par_even_i(par_even),
        .trig_lvl_i(trig), .pop_i(pop), .ovr_clr_i(ovr_clr),
        .rd_data_o(rd_data), .data_avail_o(avail), .not_full_o(not_full),
        .fifo_cnt_o(cnt), .busy_o(busy), .ovr_err_o(ovr), .frm_err_o(frm),
        .par_err_o(par), .brk_err_o(brk), .irq_thresh_o(irq_th),
        .irq_timeout_o(irq_to), .irq_err_o(irq_er)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bit_out(input logic b);
        rxd = b;
        repeat (16) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] v, input logic flip,
                              input logic st1, input logic st2);
        logic p;
        p = 1'b0;
        bit_out(1'b0);
        for (int i = 0; i < 5 + int'(wlen); i++) begin
            bit_out(v[i]);
            p ^= v[i];
        end
        if (par_en) bit_out((par_even ? p : ~p) ^ flip);
        bit_out(st1);
        if (two_stop) bit_out(st2);
        rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_pop;
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        @(negedge clk);
    endtask

    // [14:13] wlen, [12] par_en, [11] par_even, [10] two_stop, [9] flip, [7:0] value
    localparam logic [15:0] VEC [6] = '{
        {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
        {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF},
        {2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h2A},
        {2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h5B},
        {2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h81},
        {2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h3C}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] m, e;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cnt == 0 && !avail && not_full && !busy, "R1 queue", {cnt, avail, not_full, busy}, 5'b0001_0);
        chk({ovr, frm, par, brk, irq_to, irq_er} == 0, "R1 flags", {ovr, frm, par, brk, irq_to, irq_er}, 0);
        rx_en = 1'b1;

        // R2, R4 vector walk
        for (int k = 0; k < 6; k++) begin
            wlen = VEC[k][14:13]; par_en = VEC[k][12]; par_even = VEC[k][11];
            two_stop = VEC[k][10];
            send_frame(VEC[k][7:0], VEC[k][9], 1'b1, 1'b1);
            m = 8'hFF >> (3 - int'(wlen));
            e = VEC[k][7:0] & m;
            chk(avail && rd_data == {VEC[k][9] & VEC[k][12], 7'b0, e}, "R2 R4 vector", rd_data,
                {VEC[k][9] & VEC[k][12], 7'b0, e});
            chk(par == (VEC[k][9] & VEC[k][12]), "R4 parity status", par, VEC[k][9]);
            do_pop();
        end
        wlen = 2'd3; par_en = 1'b0; two_stop = 1'b0;

        // R3 short glitch
        rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
        repeat (40) @(negedge clk);
        chk(!busy && cnt == 0, "R3 glitch", {busy, cnt}, 0);

        // R5 framing, single stop
        send_frame(8'h55, 1'b0, 1'b0, 1'b1);
        chk(rd_data == 16'h4055 && frm && !brk && irq_er, "R5 framing", rd_data, 16'h4055);
        do_pop();
        chk(!frm && !irq_er, "R5 clears on pop", {frm, irq_er}, 0);
        // R5 second stop low
        two_stop = 1'b1;
        send_frame(8'hA5, 1'b0, 1'b1, 1'b0);
        chk(rd_data == 16'h40A5 && frm, "R5 second stop", rd_data, 16'h40A5);
        do_pop();
        two_stop = 1'b0;

        // R6 break
        send_frame(8'h00, 1'b0, 1'b0, 1'b0);
        chk(rd_data == 16'h6000 && brk && frm, "R6 break", rd_data, 16'h6000);
        do_pop();

        // R12 disabled
        rx_en = 1'b0;
        send_frame(8'h12, 1'b0, 1'b1, 1'b1);
        chk(cnt == 0 && !avail, "R12 disabled", cnt, 0);
        rx_en = 1'b1;

        // R9, R10
        trig = 5'd3;
        send_frame(8'h30, 1'b0, 1'b1, 1'b1);
        send_frame(8'h31, 1'b0, 1'b1, 1'b1);
        chk(cnt == 2 && !irq_th, "R9 below level", {cnt, irq_th}, {5'd2, 1'b0});
        repeat (490) @(negedge clk);
        chk(!irq_to, "R10 not yet", irq_to, 0);
        repeat (40) @(negedge clk);
        chk(irq_to, "R10 timeout", irq_to, 1);
        send_frame(8'h32, 1'b0, 1'b1, 1'b1);
        chk(!irq_to && cnt == 3 && irq_th, "R9 R10 arrival", {irq_to, cnt, irq_th}, {1'b0, 5'd3, 1'b1});
        do_pop(); do_pop(); do_pop();
        chk(cnt == 0 && !irq_to, "R10 empty", {cnt, irq_to}, 0);

        // R7 fill to 16
        for (int i = 0; i < 16; i++) send_frame(8'h30 + 8'(i), 1'b0, 1'b1, 1'b1);
        chk(cnt == 16 && !not_full && irq_th, "R7 full", {cnt, not_full}, {5'd16, 1'b0});
        // R8 drop
        send_frame(8'hEE, 1'b0, 1'b1, 1'b1);
        chk(ovr && cnt == 16 && rd_data == 16'h0030, "R8 overrun", {ovr, rd_data}, {1'b1, 16'h0030});
        chk(irq_er, "R11 overrun irq", irq_er, 1);
        ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0; @(negedge clk);
        chk(!ovr && !irq_er, "R8 clear", {ovr, irq_er}, 0);

        // R8 pop in completion cycle
        fork
            send_frame(8'h77, 1'b0, 1'b1, 1'b1);
            begin
                do @(negedge clk); while (!busy);
                do @(negedge clk); while (busy);
                pop = 1'b1; @(negedge clk); pop = 1'b0;
            end
        join
        chk(!ovr && cnt == 16 && rd_data == 16'h0031, "R8 pop same cycle", {ovr, rd_data}, 16'h0031);

        // R8 clear in completion cycle
        fork
            send_frame(8'h99, 1'b0, 1'b1, 1'b1);
            begin
                do @(negedge clk); while (!busy);
                do @(negedge clk); while (busy);
                ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
            end
        join
        chk(ovr && cnt == 16, "R8 set wins", {ovr, cnt}, {1'b1, 5'd16});

        // R7 drain order
        for (int i = 0; i < 16; i++) begin
            e = (i < 15) ? 8'h31 + 8'(i) : 8'h77;
            chk(rd_data == {8'h00, e}, "R7 order", rd_data, e);
            do_pop();
        end
        do_pop();
        chk(cnt == 0 && !avail && not_full, "R7 empty pop", cnt, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule